// File: doc/BRIEF.md
# Ethernet Task Launch Bridge

The bridge lets processing elements on one node start tasks on other nodes by carrying task-launch requests and task results inside raw Ethernet frames. On the receive side it parses a 64-bit AXI4-Stream of frames and keeps only those addressed to the node's own MAC address. Launch frames become 512-bit launch requests in the same format that the on-chip launch stream uses. Result frames become result transfers for the local processing elements. For every accepted launch, the sender's MAC address is filed under the task's tag, so the result can be returned to that sender without any central coordinator.

On the local side, the bridge takes launch requests from the processing elements and routes each one. If a local processing element implements the requested kernel, the request goes to the local task queue. If not, the request is wrapped in a launch frame and sent to the peer MAC address supplied by an external lookup block. Results of network-originated tasks are framed and sent back to the MAC address stored for their task.

Top module: `eth_launch_bridge`

## Requirements
- R1: After reset, `lq_valid`, `tx_tvalid` and `res_out_valid` are low and `rx_tready` is high.
- R2: A received frame whose destination MAC (beat 0 bits 63:16) differs from `own_mac` produces no local-queue transfer and no result transfer.
- R3: A received launch frame of exactly 7 beats with the correct destination MAC is delivered on `lq_data`. The frame carries EtherType 0x88B5 in beat 1 bits 31:16, the kernel ID in beat 1 bits 15:0, the task ID in beat 2 bits 63:48, and arguments 0 to 3 in beats 3 to 6. On `lq_data`, argument i sits at bits 64i+63:64i, the task ID at bits 271:256 and the kernel ID at bits 287:272, and all higher bits are zero.
- R4: The source MAC of an accepted launch frame (beat 0 bits 15:0 as the upper 16 bits, beat 1 bits 63:32 as the lower 32 bits) is stored under the low 4 bits of its task ID. A later result on `res_in_*` for that tag leaves as a 4-beat frame with the following layout: destination is the stored MAC, source is `own_mac`, EtherType is 0x88B6, beat 1 bits 15:0 are zero, beat 2 carries the task ID in bits 63:48 with zeros below, and beat 3 carries the value. A newer launch with the same tag replaces the stored MAC.
- R5: A local launch request whose kernel ID is below 16 and whose bit is set in the local-kernel mask (default 0x00FF) passes unchanged to `lq_data` and produces no transmit frame.
- R6: A local launch request for any other kernel ID leaves as a 7-beat launch frame. Its destination is `peer_mac` as sampled at acceptance, its source is `own_mac`, its EtherType is 0x88B5, and its fields are laid out as in R3. It produces no local-queue transfer.
- R7: Received frames with EtherType 0x88B7 (load broadcast) or any EtherType other than 0x88B5 and 0x88B6 produce no output.
- R8: A received frame is discarded if it ends before its full length, runs past its full length, or has any beat whose `rx_tkeep` is not all ones. The next well-formed frame is still accepted.
- R9: A received result frame of exactly 4 beats (EtherType 0x88B6, task ID in beat 2 bits 63:48, value in beat 3) is delivered on `res_out_task` and `res_out_value`.
- R10: While a received launch or result has not been taken, `rx_tready` stays low and the pending output holds its value.
- R11: When a result and a network-bound launch request are both waiting while the transmitter is idle, the result frame is sent first.
- R12: Every transmitted beat has `tx_tkeep` all ones, `tlast` is set only on the final beat, and the beat holds its value while `tx_tready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_mac | input | 48 | This node's MAC address |
| peer_mac | input | 48 | Remote node chosen by the lookup block for the pending request |
| pe_req_valid | input | 1 | Local launch request valid |
| pe_req_ready | output | 1 | Local launch request accepted |
| pe_req_data | input | 512 | Local launch request |
| lq_valid | output | 1 | Request to local task queue valid |
| lq_ready | input | 1 | Local task queue accepts |
| lq_data | output | 512 | Request to local task queue |
| res_in_valid | input | 1 | Result of a network-originated task valid |
| res_in_ready | output | 1 | Result accepted for framing |
| res_in_task | input | 16 | Task ID of that result |
| res_in_value | input | 64 | Result value |
| res_out_valid | output | 1 | Result received from the network valid |
| res_out_ready | input | 1 | Local consumer accepts the result |
| res_out_task | output | 16 | Task ID of the received result |
| res_out_value | output | 64 | Received result value |
| rx_tdata | input | 64 | Receive stream data |
| rx_tkeep | input | 8 | Receive stream byte enables |
| rx_tvalid | input | 1 | Receive stream valid |
| rx_tlast | input | 1 | Receive stream last beat |
| rx_tready | output | 1 | Receive stream ready |
| tx_tdata | output | 64 | Transmit stream data |
| tx_tkeep | output | 8 | Transmit stream byte enables |
| tx_tvalid | output | 1 | Transmit stream valid |
| tx_tlast | output | 1 | Transmit stream last beat |
| tx_tready | input | 1 | Transmit stream ready |

## Verification
A wrong beat counter or sticky discard flag in the parser shows up at the first frame after a malformed one: a good frame is lost, or a bad one leaks onto `lq_data`. This is visible within one frame time. A corrupted source-MAC table entry stays hidden until a result for that tag is returned, and then appears in beat 0 of the transmitted frame. A misrouted kernel shows up at once, as a transfer on the wrong output in the same cycle the request is accepted. Every output transfer is compared with a model queue the moment it happens, and each phase ends by confirming that nothing expected was left over.

// File: rtl/elb_pkg.sv
package elb_pkg;
    localparam int MAC_W  = 48;
    localparam int KID_W  = 16;
    localparam int TID_W  = 16;
    localparam int ARG_W  = 64;
    localparam int ARG_N  = 4;
    localparam int LREQ_W = 512;
    localparam int NET_W  = 64;
    localparam int KEEP_W = NET_W / 8;
    localparam int BEAT_W = 4;
    localparam int AIX_W  = $clog2(ARG_N);
    localparam int RSV_W  = LREQ_W - KID_W - TID_W - ARG_N * ARG_W;

    localparam logic [BEAT_W-1:0] B_HDR      = BEAT_W'(2);
    localparam logic [BEAT_W-1:0] B_OFS      = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] LAUNCH_LEN = B_OFS + BEAT_W'(ARG_N);
    localparam logic [BEAT_W-1:0] RESULT_LEN = B_OFS + BEAT_W'(1);

    localparam logic [15:0] ET_LAUNCH = 16'h88B5;
    localparam logic [15:0] ET_RESULT = 16'h88B6;
    localparam logic [15:0] ET_LOAD   = 16'h88B7;

    typedef enum logic [1:0] {FK_NONE, FK_LAUNCH, FK_RESULT, FK_LOAD} fkind_e;

    typedef logic [ARG_N-1:0][ARG_W-1:0] argv_t;

    typedef struct packed {
        logic [RSV_W-1:0] rsv;
        logic [KID_W-1:0] kid;
        logic [TID_W-1:0] tid;
        argv_t            args;
    } lreq_t;

    typedef struct packed {
        logic             is_result;
        logic [MAC_W-1:0] dst;
        logic [KID_W-1:0] kid;
        logic [TID_W-1:0] tid;
        argv_t            args;
    } txjob_t;

    function automatic fkind_e kind_of(input logic [15:0] et);
        case (et)
            ET_LAUNCH: return FK_LAUNCH;
            ET_RESULT: return FK_RESULT;
            ET_LOAD:   return FK_LOAD;
            default:   return FK_NONE;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] frame_len(input fkind_e k);
        case (k)
            FK_LAUNCH: return LAUNCH_LEN;
            FK_RESULT: return RESULT_LEN;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/elb_rx_parse.sv
module elb_rx_parse
    import elb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MAC_W-1:0]  own_mac,
    input  logic [NET_W-1:0]  rx_tdata,
    input  logic [KEEP_W-1:0] rx_tkeep,
    input  logic              rx_tvalid,
    input  logic              rx_tlast,
    output logic              rx_tready,
    output logic              lch_v,
    output lreq_t             lch_q,
    input  logic              lch_take,
    output logic              res_v,
    output logic [TID_W-1:0]  res_tid,
    output logic [ARG_W-1:0]  res_val,
    input  logic              res_take,
    output logic              src_we,
    output logic [TID_W-1:0]  src_tid,
    output logic [MAC_W-1:0]  src_mac
);
    logic [BEAT_W-1:0] beat_q;
    logic              bad_q;
    fkind_e            kind_q;
    logic [MAC_W-1:0]  smac_q;
    logic [KID_W-1:0]  kid_q;
    logic [TID_W-1:0]  tid_q;
    argv_t             args_q;

    logic              fire;
    fkind_e            kind_n;
    logic [MAC_W-1:0]  smac_n;
    logic [KID_W-1:0]  kid_n;
    logic [TID_W-1:0]  tid_n;
    argv_t             args_n;
    logic              bad_n;
    logic              done_ok;
    logic [BEAT_W-1:0] slot;

    assign rx_tready = !lch_v && !res_v;
    assign fire      = rx_tvalid && rx_tready;
    assign slot      = beat_q - B_OFS;

    always_comb begin
        kind_n = (beat_q == BEAT_W'(1)) ? kind_of(rx_tdata[31:16]) : kind_q;
        smac_n = smac_q;
        if (beat_q == '0)         smac_n[MAC_W-1:32] = rx_tdata[15:0];
        if (beat_q == BEAT_W'(1)) smac_n[31:0]       = rx_tdata[63:32];
        kid_n  = (beat_q == BEAT_W'(1)) ? rx_tdata[KID_W-1:0] : kid_q;
        tid_n  = (beat_q == B_HDR) ? rx_tdata[63:64-TID_W] : tid_q;
        args_n = args_q;
        if (beat_q >= B_OFS && beat_q < LAUNCH_LEN)
            args_n[slot[AIX_W-1:0]] = rx_tdata;
        bad_n = ((beat_q == '0) ? 1'b0 : bad_q)
              | (rx_tkeep != '1)
              | ((beat_q == '0) && (rx_tdata[63:16] != own_mac))
              | ((beat_q == BEAT_W'(1)) && (kind_n == FK_NONE || kind_n == FK_LOAD))
              | ((beat_q >= B_HDR) && (beat_q >= frame_len(kind_n)));
        done_ok = fire && rx_tlast && !bad_n && ((beat_q + BEAT_W'(1)) == frame_len(kind_n));
    end

    assign src_we  = done_ok && (kind_n == FK_LAUNCH);
    assign src_tid = tid_n;
    assign src_mac = smac_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            bad_q   <= 1'b0;
            kind_q  <= FK_NONE;
            smac_q  <= '0;
            kid_q   <= '0;
            tid_q   <= '0;
            args_q  <= '0;
            lch_v   <= 1'b0;
            lch_q   <= '0;
            res_v   <= 1'b0;
            res_tid <= '0;
            res_val <= '0;
        end else begin
            if (lch_v && lch_take) lch_v <= 1'b0;
            if (res_v && res_take) res_v <= 1'b0;
            if (fire) begin
                if (rx_tlast)              beat_q <= '0;
                else if (beat_q != '1)     beat_q <= beat_q + BEAT_W'(1);
                bad_q  <= bad_n;
                kind_q <= kind_n;
                smac_q <= smac_n;
                kid_q  <= kid_n;
                tid_q  <= tid_n;
                args_q <= args_n;
                if (done_ok) begin
                    if (kind_n == FK_LAUNCH) begin
                        lch_v      <= 1'b1;
                        lch_q.rsv  <= '0;
                        lch_q.kid  <= kid_n;
                        lch_q.tid  <= tid_n;
                        lch_q.args <= args_n;
                    end else begin
                        res_v   <= 1'b1;
                        res_tid <= tid_n;
                        res_val <= args_n[0];
                    end
                end
            end
        end
    end

    p_launch_hold_r10: assert property (@(posedge clk) disable iff (rst)
        lch_v && !lch_take |=> lch_v && $stable(lch_q));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        res_v && !res_take |=> res_v && $stable(res_tid) && $stable(res_val));

    p_emit_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lch_v) || $rose(res_v) |-> $past(rx_tvalid && rx_tlast));
endmodule

// File: rtl/elb_src_table.sv
module elb_src_table
    import elb_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [TID_W-1:0] wtid,
    input  logic [MAC_W-1:0] wmac,
    input  logic [TID_W-1:0] rtid,
    output logic [MAC_W-1:0] rmac
);
    localparam int DEPTH = 1 << TAG_W;

    logic [MAC_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wtid[TAG_W-1:0]] <= wmac;
        end
    end

    assign rmac = mem_q[rtid[TAG_W-1:0]];

    p_store_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(wtid[TAG_W-1:0])] == $past(wmac));
endmodule

// File: rtl/elb_tx_frame.sv
module elb_tx_frame
    import elb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MAC_W-1:0]  own_mac,
    input  logic              job_v,
    input  txjob_t            job,
    output logic              job_rdy,
    output logic [NET_W-1:0]  tx_tdata,
    output logic [KEEP_W-1:0] tx_tkeep,
    output logic              tx_tvalid,
    output logic              tx_tlast,
    input  logic              tx_tready
);
    logic              busy_q;
    txjob_t            job_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] len;
    logic [BEAT_W-1:0] slot;

    assign len       = job_q.is_result ? RESULT_LEN : LAUNCH_LEN;
    assign slot      = beat_q - B_OFS;
    assign job_rdy   = !busy_q;
    assign tx_tvalid = busy_q;
    assign tx_tkeep  = '1;
    assign tx_tlast  = (beat_q == len - BEAT_W'(1));

    always_comb begin
        case (beat_q)
            BEAT_W'(0): tx_tdata = {job_q.dst, own_mac[MAC_W-1:32]};
            BEAT_W'(1): tx_tdata = {own_mac[31:0],
                                    job_q.is_result ? ET_RESULT : ET_LAUNCH,
                                    job_q.is_result ? {KID_W{1'b0}} : job_q.kid};
            B_HDR:      tx_tdata = {job_q.tid, {(NET_W-TID_W){1'b0}}};
            default:    tx_tdata = job_q.args[slot[AIX_W-1:0]];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            job_q  <= '0;
            beat_q <= '0;
        end else if (!busy_q) begin
            if (job_v) begin
                busy_q <= 1'b1;
                job_q  <= job;
                beat_q <= '0;
            end
        end else if (tx_tready) begin
            if (tx_tlast) busy_q <= 1'b0;
            else          beat_q <= beat_q + BEAT_W'(1);
        end
    end

    p_tx_hold_r12: assert property (@(posedge clk) disable iff (rst)
        tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

    p_tx_start_r12: assert property (@(posedge clk) disable iff (rst)
        job_v && job_rdy |=> tx_tvalid && !tx_tlast);
endmodule

// File: rtl/eth_launch_bridge.sv
module eth_launch_bridge
    import elb_pkg::*;
#(
    parameter int                 TAG_W  = 4,
    parameter int                 KMAP_N = 16,
    parameter logic [KMAP_N-1:0]  KMASK  = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MAC_W-1:0]  own_mac,
    input  logic [MAC_W-1:0]  peer_mac,
    input  logic              pe_req_valid,
    output logic              pe_req_ready,
    input  logic [LREQ_W-1:0] pe_req_data,
    output logic              lq_valid,
    input  logic              lq_ready,
    output logic [LREQ_W-1:0] lq_data,
    input  logic              res_in_valid,
    output logic              res_in_ready,
    input  logic [TID_W-1:0]  res_in_task,
    input  logic [ARG_W-1:0]  res_in_value,
    output logic              res_out_valid,
    input  logic              res_out_ready,
    output logic [TID_W-1:0]  res_out_task,
    output logic [ARG_W-1:0]  res_out_value,
    input  logic [NET_W-1:0]  rx_tdata,
    input  logic [KEEP_W-1:0] rx_tkeep,
    input  logic              rx_tvalid,
    input  logic              rx_tlast,
    output logic              rx_tready,
    output logic [NET_W-1:0]  tx_tdata,
    output logic [KEEP_W-1:0] tx_tkeep,
    output logic              tx_tvalid,
    output logic              tx_tlast,
    input  logic              tx_tready
);
    localparam int KIX_W = $clog2(KMAP_N);

    lreq_t            pe_q;
    logic             is_local;
    logic             net_v;
    lreq_t            net_q;
    logic             tbl_we;
    logic [TID_W-1:0] tbl_wtid;
    logic [MAC_W-1:0] tbl_wmac;
    logic [MAC_W-1:0] tbl_rmac;
    logic             job_v;
    logic             job_rdy;
    txjob_t           job;
    logic             remote_take;

    assign pe_q     = lreq_t'(pe_req_data);
    assign is_local = (pe_q.kid < KID_W'(KMAP_N)) && KMASK[pe_q.kid[KIX_W-1:0]];

    elb_rx_parse u_rx (
        .clk       (clk),
        .rst       (rst),
        .own_mac   (own_mac),
        .rx_tdata  (rx_tdata),
        .rx_tkeep  (rx_tkeep),
        .rx_tvalid (rx_tvalid),
        .rx_tlast  (rx_tlast),
        .rx_tready (rx_tready),
        .lch_v     (net_v),
        .lch_q     (net_q),
        .lch_take  (lq_ready),
        .res_v     (res_out_valid),
        .res_tid   (res_out_task),
        .res_val   (res_out_value),
        .res_take  (res_out_ready),
        .src_we    (tbl_we),
        .src_tid   (tbl_wtid),
        .src_mac   (tbl_wmac)
    );

    elb_src_table #(.TAG_W(TAG_W)) u_tbl (
        .clk  (clk),
        .rst  (rst),
        .we   (tbl_we),
        .wtid (tbl_wtid),
        .wmac (tbl_wmac),
        .rtid (res_in_task),
        .rmac (tbl_rmac)
    );

    // Local queue: network launches take precedence over local ones.
    assign lq_valid = net_v || (pe_req_valid && is_local);
    assign lq_data  = net_v ? LREQ_W'(net_q) : pe_req_data;

    // Transmit side: results are framed before outgoing launches.
    assign res_in_ready = job_rdy;
    assign remote_take  = job_rdy && !res_in_valid && pe_req_valid && !is_local;
    assign pe_req_ready = is_local ? (lq_ready && !net_v) : remote_take;
    assign job_v        = res_in_valid || (pe_req_valid && !is_local);

    always_comb begin
        job = '0;
        if (res_in_valid) begin
            job.is_result = 1'b1;
            job.dst       = tbl_rmac;
            job.tid       = res_in_task;
            job.args[0]   = res_in_value;
        end else begin
            job.dst  = peer_mac;
            job.kid  = pe_q.kid;
            job.tid  = pe_q.tid;
            job.args = pe_q.args;
        end
    end

    elb_tx_frame u_tx (
        .clk       (clk),
        .rst       (rst),
        .own_mac   (own_mac),
        .job_v     (job_v),
        .job       (job),
        .job_rdy   (job_rdy),
        .tx_tdata  (tx_tdata),
        .tx_tkeep  (tx_tkeep),
        .tx_tvalid (tx_tvalid),
        .tx_tlast  (tx_tlast),
        .tx_tready (tx_tready)
    );

    p_local_route_r5: assert property (@(posedge clk) disable iff (rst)
        pe_req_valid && pe_req_ready && is_local |-> lq_valid && lq_ready && (lq_data == pe_req_data));

    p_remote_route_r6: assert property (@(posedge clk) disable iff (rst)
        pe_req_valid && pe_req_ready && !is_local |=> tx_tvalid && (tx_tdata[63:16] == $past(peer_mac)));

    p_result_first_r11: assert property (@(posedge clk) disable iff (rst)
        res_in_valid && job_rdy |-> !(pe_req_valid && pe_req_ready && !is_local));
endmodule

// File: tb/eth_launch_bridge_tb.sv
module eth_launch_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;
    localparam logic [47:0] OWN  = 48'h02_00_00_00_00_11;
    localparam logic [47:0] MAC_A = 48'h02_AA_10_20_30_40;
    localparam logic [47:0] MAC_B = 48'h02_BB_55_66_77_88;
    localparam logic [47:0] PEER = 48'h02_CC_01_02_03_04;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [47:0]  peer_mac = PEER;
    logic         pe_req_valid = 1'b0;
    logic         pe_req_ready;
    logic [511:0] pe_req_data = '0;
    logic         lq_valid;
    logic         lq_ready = 1'b1;
    logic [511:0] lq_data;
    logic         res_in_valid = 1'b0;
    logic         res_in_ready;
    logic [15:0]  res_in_task = '0;
    logic [63:0]  res_in_value = '0;
    logic         res_out_valid;
    logic         res_out_ready = 1'b1;
    logic [15:0]  res_out_task;
    logic [63:0]  res_out_value;
    logic [63:0]  rx_tdata = '0;
    logic [7:0]   rx_tkeep = '0;
    logic         rx_tvalid = 1'b0;
    logic         rx_tlast = 1'b0;
    logic         rx_tready;
    logic [63:0]  tx_tdata;
    logic [7:0]   tx_tkeep;
    logic         tx_tvalid;
    logic         tx_tlast;
    logic         tx_tready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_launch_bridge u_dut (
        .clk(clk), .rst(rst), .own_mac(OWN), .peer_mac(peer_mac),
        .pe_req_valid(pe_req_valid), .pe_req_ready(pe_req_ready), .pe_req_data(pe_req_data),
        .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_data(lq_data),
        .res_in_valid(res_in_valid), .res_in_ready(res_in_ready),
        .res_in_task(res_in_task), .res_in_value(res_in_value),
        .res_out_valid(res_out_valid), .res_out_ready(res_out_ready),
        .res_out_task(res_out_task), .res_out_value(res_out_value),
        .rx_tdata(rx_tdata), .rx_tkeep(rx_tkeep), .rx_tvalid(rx_tvalid),
        .rx_tlast(rx_tlast), .rx_tready(rx_tready),
        .tx_tdata(tx_tdata), .tx_tkeep(tx_tkeep), .tx_tvalid(tx_tvalid),
        .tx_tlast(tx_tlast), .tx_tready(tx_tready)
    );

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";

    logic [511:0] lq_exp[$];
    string        lq_tag[$];
    logic [79:0]  res_exp[$];
    string        res_tag[$];
    logic [64:0]  tx_exp[$];
    string        tx_tag[$];

    logic [63:0] fb[16];
    logic [7:0]  fk[16];
    int          fn;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [511:0] pack_req(input logic [15:0] kid, input logic [15:0] tid,
                                              input logic [255:0] av);
        return {224'h0, kid, tid, av};
    endfunction

    function automatic logic [255:0] mk_args(input logic [63:0] seed);
        return {seed ^ 64'h3333, seed ^ 64'h2222, seed ^ 64'h1111, seed};
    endfunction

    task automatic build_launch(input logic [47:0] dst, input logic [47:0] src, input logic [15:0] et,
                                input logic [15:0] kid, input logic [15:0] tid, input logic [255:0] av);
        fb[0] = {dst, src[47:32]};
        fb[1] = {src[31:0], et, kid};
        fb[2] = {tid, 48'h0};
        for (int i = 0; i < 4; i++) fb[3+i] = av[64*i +: 64];
        for (int i = 0; i < 16; i++) fk[i] = 8'hFF;
        fn = 7;
    endtask

    task automatic build_result(input logic [47:0] dst, input logic [47:0] src,
                                input logic [15:0] tid, input logic [63:0] val);
        fb[0] = {dst, src[47:32]};
        fb[1] = {src[31:0], 16'h88B6, 16'h0};
        fb[2] = {tid, 48'h0};
        fb[3] = val;
        for (int i = 0; i < 16; i++) fk[i] = 8'hFF;
        fn = 4;
    endtask

    task automatic send_frame();
        for (int i = 0; i < fn; i++) begin
            rx_tdata  = fb[i];
            rx_tkeep  = fk[i];
            rx_tlast  = (i == fn - 1);
            rx_tvalid = 1'b1;
            @(negedge clk);
            while (!rx_tready) @(negedge clk);
            @(posedge clk); #1;
        end
        rx_tvalid = 1'b0;
        rx_tlast  = 1'b0;
    endtask

    task automatic pe_send(input logic [511:0] d);
        pe_req_data  = d;
        pe_req_valid = 1'b1;
        @(negedge clk);
        while (!pe_req_ready) @(negedge clk);
        @(posedge clk); #1;
        pe_req_valid = 1'b0;
    endtask

    task automatic res_send(input logic [15:0] tid, input logic [63:0] val);
        res_in_task  = tid;
        res_in_value = val;
        res_in_valid = 1'b1;
        @(negedge clk);
        while (!res_in_ready) @(negedge clk);
        @(posedge clk); #1;
        res_in_valid = 1'b0;
    endtask

    task automatic exp_tx_launch(input logic [47:0] dst, input logic [15:0] kid, input logic [15:0] tid,
                                 input logic [255:0] av, input string tag);
        tx_exp.push_back({1'b0, dst, OWN[47:32]});          tx_tag.push_back(tag);
        tx_exp.push_back({1'b0, OWN[31:0], 16'h88B5, kid}); tx_tag.push_back(tag);
        tx_exp.push_back({1'b0, tid, 48'h0});               tx_tag.push_back(tag);
        for (int i = 0; i < 4; i++) begin
            tx_exp.push_back({(i == 3), av[64*i +: 64]});
            tx_tag.push_back(tag);
        end
    endtask

    task automatic exp_tx_result(input logic [47:0] dst, input logic [15:0] tid,
                                 input logic [63:0] val, input string tag);
        tx_exp.push_back({1'b0, dst, OWN[47:32]});            tx_tag.push_back(tag);
        tx_exp.push_back({1'b0, OWN[31:0], 16'h88B6, 16'h0}); tx_tag.push_back(tag);
        tx_exp.push_back({1'b0, tid, 48'h0});                 tx_tag.push_back(tag);
        tx_exp.push_back({1'b1, val});                        tx_tag.push_back(tag);
    endtask

    task automatic settle(input string tag);
        repeat (20) @(posedge clk);
        #1;
        chk(lq_exp.size() == 0 && res_exp.size() == 0 && tx_exp.size() == 0, tag,
            "expected outputs left over",
            512'(lq_exp.size() + res_exp.size() + tx_exp.size()), 512'(0));
    endtask

    // Per-clock comparison of every output transfer against the model queues.
    logic [511:0] m_l;
    logic [79:0]  m_r;
    logic [64:0]  m_t;
    string        m_s;
    always @(negedge clk) begin
        if (!rst) begin
            if (lq_valid && lq_ready) begin
                if (lq_exp.size() == 0) chk(1'b0, cur_tag, "unexpected local-queue transfer", lq_data, '0);
                else begin
                    m_l = lq_exp.pop_front(); m_s = lq_tag.pop_front();
                    chk(lq_data == m_l, m_s, "local-queue data", lq_data, m_l);
                end
            end
            if (res_out_valid && res_out_ready) begin
                if (res_exp.size() == 0) chk(1'b0, cur_tag, "unexpected result out", {res_out_task, res_out_value}, '0);
                else begin
                    m_r = res_exp.pop_front(); m_s = res_tag.pop_front();
                    chk({res_out_task, res_out_value} == m_r, m_s, "result out", {res_out_task, res_out_value}, m_r);
                end
            end
            if (tx_tvalid && tx_tready) begin
                chk(tx_tkeep == 8'hFF, "R12", "tx keep", tx_tkeep, 8'hFF);
                if (tx_exp.size() == 0) chk(1'b0, cur_tag, "unexpected tx beat", {tx_tlast, tx_tdata}, '0);
                else begin
                    m_t = tx_exp.pop_front(); m_s = tx_tag.pop_front();
                    chk({tx_tlast, tx_tdata} == m_t, m_s, "tx beat", {tx_tlast, tx_tdata}, m_t);
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] av;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!lq_valid && !tx_tvalid && !res_out_valid && rx_tready, "R1", "reset outputs",
            {lq_valid, tx_tvalid, res_out_valid, rx_tready}, 4'b0001);
        @(posedge clk); #1;

        // R3 accepted launch frame from MAC_A, task 5
        cur_tag = "R3";
        av = mk_args(64'hA000_0000_0000_0001);
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0009, 16'd5, av);
        lq_exp.push_back(pack_req(16'h0009, 16'd5, av)); lq_tag.push_back("R3");
        send_frame();
        settle("R3");

        // R2 destination mismatch
        cur_tag = "R2";
        build_launch(MAC_B, MAC_A, 16'h88B5, 16'h0001, 16'd6, mk_args(64'h77));
        send_frame();
        build_result(MAC_B, MAC_A, 16'd6, 64'h1234);
        send_frame();
        settle("R2");

        // R7 load broadcast and unknown EtherType
        cur_tag = "R7";
        build_launch(OWN, MAC_A, 16'h88B7, 16'h0001, 16'd7, mk_args(64'h88));
        send_frame();
        build_launch(OWN, MAC_A, 16'h0800, 16'h0001, 16'd7, mk_args(64'h99));
        send_frame();
        settle("R7");

        // R8 short frame, partial keep, overlong frame, then recovery
        cur_tag = "R8";
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0002, 16'd8, mk_args(64'h10));
        fn = 5;
        send_frame();
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0002, 16'd8, mk_args(64'h20));
        fk[3] = 8'h0F;
        send_frame();
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0002, 16'd8, mk_args(64'h30));
        fb[7] = 64'hDEAD; fn = 8;
        send_frame();
        settle("R8");
        av = mk_args(64'h40);
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0002, 16'd8, av);
        lq_exp.push_back(pack_req(16'h0002, 16'd8, av)); lq_tag.push_back("R8");
        send_frame();
        settle("R8");

        // R4 result returned to stored sender, then tag overwrite by MAC_B
        cur_tag = "R4";
        exp_tx_result(MAC_A, 16'd5, 64'hCAFE_0005, "R4");
        res_send(16'd5, 64'hCAFE_0005);
        settle("R4");
        av = mk_args(64'hB0);
        build_launch(OWN, MAC_B, 16'h88B5, 16'h0003, 16'd21, av);
        lq_exp.push_back(pack_req(16'h0003, 16'd21, av)); lq_tag.push_back("R4");
        send_frame();
        exp_tx_result(MAC_B, 16'd21, 64'hCAFE_0021, "R4");
        res_send(16'd21, 64'hCAFE_0021);
        settle("R4");

        // R5 local kernel goes to local queue unchanged
        cur_tag = "R5";
        av = mk_args(64'h55);
        lq_exp.push_back(pack_req(16'h0003, 16'd30, av)); lq_tag.push_back("R5");
        pe_send(pack_req(16'h0003, 16'd30, av));
        settle("R5");

        // R6 non-local kernels go to the network, with a transmit stall (R12)
        cur_tag = "R6";
        tx_tready = 1'b0;
        av = mk_args(64'h66);
        exp_tx_launch(PEER, 16'h0009, 16'd31, av, "R6");
        pe_send(pack_req(16'h0009, 16'd31, av));
        peer_mac = MAC_B;
        repeat (4) @(posedge clk);
        #1;
        chk(tx_tvalid && tx_tdata == {PEER, OWN[47:32]} && !tx_tlast, "R12", "stalled beat held",
            {tx_tvalid, tx_tlast, tx_tdata}, {1'b1, 1'b0, PEER, OWN[47:32]});
        tx_tready = 1'b1;
        peer_mac = PEER;
        settle("R6");
        av = mk_args(64'h67);
        exp_tx_launch(PEER, 16'h00C8, 16'd32, av, "R6");
        pe_send(pack_req(16'h00C8, 16'd32, av));
        settle("R6");

        // R9 received result frame
        cur_tag = "R9";
        res_exp.push_back({16'd40, 64'hFEED_BEEF_0000_0040}); res_tag.push_back("R9");
        build_result(OWN, MAC_A, 16'd40, 64'hFEED_BEEF_0000_0040);
        send_frame();
        settle("R9");

        // R10 backpressure from the local queue stalls receive
        cur_tag = "R10";
        lq_ready = 1'b0;
        av = mk_args(64'h100);
        build_launch(OWN, MAC_A, 16'h88B5, 16'h0004, 16'd50, av);
        lq_exp.push_back(pack_req(16'h0004, 16'd50, av)); lq_tag.push_back("R10");
        send_frame();
        repeat (3) @(posedge clk);
        #1;
        chk(!rx_tready && lq_valid && lq_data == pack_req(16'h0004, 16'd50, av), "R10",
            "pending launch held, rx stalled", {rx_tready, lq_valid, lq_data[287:0]},
            {1'b0, 1'b1, pack_req(16'h0004, 16'd50, av)});
        lq_ready = 1'b1;
        settle("R10");

        // R11 result framed before a simultaneous remote launch
        cur_tag = "R11";
        av = mk_args(64'h110);
        exp_tx_result(MAC_B, 16'd21, 64'h1111, "R11");
        exp_tx_launch(PEER, 16'h000A, 16'd60, av, "R11");
        fork
            res_send(16'd21, 64'h1111);
            pe_send(pack_req(16'h000A, 16'd60, av));
        join
        settle("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule